// File: doc/BRIEF.md
# Push-Button Tap Position Controller

This block turns two push buttons into a tap position of `POS_W` bits (32 taps when `POS_W` is 5). One button raises the position and the other lowers it. Both buttons are active low and rest high. Each button is first brought into the clock domain. A press then has to stay down for a full debounce time before the position moves one tap. If the button is still held, the position keeps stepping. It steps at a slow interval until the hold has lasted past a threshold, and after that at a faster interval. The position stops at both ends and never wraps.

Two side controls surround the stepping logic. A one-cycle load strobe presets the position, for example with a value recalled from storage at start-up. An inhibit input stops all movement and clears the press timers. Every time constant is a parameter counted in clock ticks. The asynchronous reset is released through a two-flop stage inside the block.

Top module: `tap_stepper`

## Requirements
- R1: After reset the position is 0. The internal reset ends on the second rising clock edge after `rst_n` goes high, and registers update from the third edge on.
- R2: A press that `up_n` or `dn_n` shows for fewer than `DEB_TICKS` consecutive synchronized cycles moves nothing.
- R3: Inputs pass through a 2-flop synchronizer. A press seen low on the up input (`up_n` = 0) raises the position by exactly one tap in its `DEB_TICKS`-th synchronized held cycle. A press on the down input (`dn_n` = 0) lowers it by exactly one tap in the same way. A change of button with no idle cycle in between restarts the debounce.
- R4: While one button stays held after its first step, a further step occurs every `SLOW_TICKS` cycles, for as long as the held count does not exceed `FAST_AFTER_TICKS`.
- R5: Once the held count exceeds `FAST_AFTER_TICKS`, steps occur every `FAST_TICKS` cycles, counted from the last step.
- R6: Stepping up at the top tap (all ones) leaves the position there. Stepping down at 0 leaves it at 0.
- R7: Releasing the button stops stepping at once. The next press starts again with debounce and then the slow interval.
- R8: While both buttons are seen low, the position does not move and the press timers are cleared.
- R9: A high `ld_stb` loads `ld_val` into the position at the next edge, and a button step in that same cycle is dropped.
- R10: While `inh` is high, no step occurs and the press timers are cleared. After `inh` drops with a button still held, the debounce counts again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_n | input | 1 | Raise button, active low |
| dn_n | input | 1 | Lower button, active low |
| inh | input | 1 | Freeze stepping and clear press timers |
| ld_stb | input | 1 | One-cycle preset strobe |
| ld_val | input | POS_W | Preset value |
| tap | output | POS_W | Current tap position |

## Verification
The bench builds the block with a debounce of 4 ticks, a slow interval of 6, a fast interval of 2 and a fast threshold of 20. With these values a hold of 30 cycles crosses debounce, two slow repeats, the switch to the fast rate and several fast repeats. A full sweep from one end of the 32-tap range to the other takes only a few dozen cycles, so saturation at both ends is reached quickly. The short windows also let a load strobe land exactly on a step cycle, and let inhibit end part-way through a hold.

// File: rtl/tapstep_pkg.sv
package tapstep_pkg;
  typedef enum logic [1:0] {
    MV_NONE = 2'd0,
    MV_UP   = 2'd1,
    MV_DN   = 2'd2
  } move_e;
endpackage

// File: rtl/tapstep_sync.sv
// Multi-bit level synchronizer, each bit resets to the idle (high) level.
module tapstep_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);
  for (genvar b = 0; b < N; b++) begin : g_bit
    logic [STAGES-1:0] sh_q;
    logic [STAGES-1:0] sh_d;
    always_comb sh_d = {sh_q[STAGES-2:0], din[b]};
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '1;
      else        sh_q <= sh_d;
    end
    assign dout[b] = sh_q[STAGES-1];
  end
endmodule

// File: rtl/tapstep_pace.sv
// Debounce and two-rate auto-repeat timing; emits one move per qualified step.
module tapstep_pace
  import tapstep_pkg::*;
#(
  parameter int DEB_TICKS        = 40000,
  parameter int SLOW_TICKS       = 250000,
  parameter int FAST_TICKS       = 50000,
  parameter int FAST_AFTER_TICKS = 1000000
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  up_q,
  input  logic  dn_q,
  input  logic  inh,
  output move_e mv
);
  localparam int HTW = $clog2(FAST_AFTER_TICKS + 2);
  localparam int SCW = $clog2(SLOW_TICKS + 1);
  localparam logic [HTW:0] HT_CAP  = (HTW+1)'(FAST_AFTER_TICKS + 1);
  localparam logic [HTW:0] HT_FAST = (HTW+1)'(FAST_AFTER_TICKS);
  localparam logic [HTW:0] HT_DEB  = (HTW+1)'(DEB_TICKS);
  localparam logic [SCW:0] IV_SLOW = (SCW+1)'(SLOW_TICKS);
  localparam logic [SCW:0] IV_FAST = (SCW+1)'(FAST_TICKS);

  logic [HTW-1:0] ht_q, ht_d, ht_eff;
  logic [SCW-1:0] sc_q, sc_d, sc_eff;
  logic [HTW:0]   ht_inc;
  logic [SCW:0]   sc_inc, intv;
  logic           last_up_q, last_up_d, last_up_en;
  logic           pu, pd, active, same, past_deb, first, rep, step;

  always_comb begin
    pu         = !up_q;
    pd         = !dn_q;
    active     = (pu ^ pd) && !inh;
    same       = active && (last_up_q == pu);
    ht_eff     = same ? ht_q : '0;
    sc_eff     = same ? sc_q : '0;
    ht_inc     = {1'b0, ht_eff} + (HTW+1)'(1);
    sc_inc     = {1'b0, sc_eff} + (SCW+1)'(1);
    past_deb   = {1'b0, ht_eff} >= HT_DEB;
    first      = ht_inc == HT_DEB;
    intv       = (ht_inc > HT_FAST) ? IV_FAST : IV_SLOW;
    rep        = past_deb && (sc_inc >= intv);
    step       = active && (first || rep);
    ht_d       = !active ? '0
               : ((ht_inc > HT_CAP) ? HT_CAP[HTW-1:0] : ht_inc[HTW-1:0]);
    sc_d       = (!active || step || !past_deb) ? '0 : sc_inc[SCW-1:0];
    last_up_en = active;
    last_up_d  = pu;
    if (!step)   mv = MV_NONE;
    else if (pu) mv = MV_UP;
    else         mv = MV_DN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ht_q      <= '0;
      sc_q      <= '0;
      last_up_q <= 1'b0;
    end else begin
      ht_q <= ht_d;
      sc_q <= sc_d;
      if (last_up_en) last_up_q <= last_up_d;
    end
  end
endmodule

// File: rtl/tapstep_pos.sv
// Saturating position register with preset priority.
module tapstep_pos
  import tapstep_pkg::*;
#(
  parameter int POS_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  move_e            mv,
  input  logic             ld_stb,
  input  logic [POS_W-1:0] ld_val,
  output logic [POS_W-1:0] pos
);
  localparam logic [POS_W-1:0] POS_TOP = '1;
  localparam logic [POS_W-1:0] POS_BOT = '0;

  logic [POS_W-1:0] pos_q, pos_d;
  logic             pos_en;

  always_comb begin
    pos_d  = pos_q;
    pos_en = 1'b0;
    if (ld_stb) begin
      pos_d  = ld_val;
      pos_en = 1'b1;
    end else if (mv == MV_UP && pos_q != POS_TOP) begin
      pos_d  = pos_q + POS_W'(1);
      pos_en = 1'b1;
    end else if (mv == MV_DN && pos_q != POS_BOT) begin
      pos_d  = pos_q - POS_W'(1);
      pos_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pos_q <= '0;
    else if (pos_en) pos_q <= pos_d;
  end

  assign pos = pos_q;
endmodule

// File: rtl/tap_stepper.sv
module tap_stepper
  import tapstep_pkg::*;
#(
  parameter int POS_W            = 5,
  parameter int DEB_TICKS        = 40000,
  parameter int SLOW_TICKS       = 250000,
  parameter int FAST_TICKS       = 50000,
  parameter int FAST_AFTER_TICKS = 1000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_n,
  input  logic             dn_n,
  input  logic             inh,
  input  logic             ld_stb,
  input  logic [POS_W-1:0] ld_val,
  output logic [POS_W-1:0] tap
);
  logic [1:0] rst_sh_q;
  logic       rst_q;
  logic [1:0] btn_q;
  logic       up_q, dn_q;
  move_e      mv;

  // Reset: asserted asynchronously, released on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh_q <= 2'b00;
    else        rst_sh_q <= {rst_sh_q[0], 1'b1};
  end
  assign rst_q = rst_sh_q[1];

  tapstep_sync #(.N(2), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_q),
    .din   ({up_n, dn_n}),
    .dout  (btn_q)
  );
  assign up_q = btn_q[1];
  assign dn_q = btn_q[0];

  tapstep_pace #(
    .DEB_TICKS        (DEB_TICKS),
    .SLOW_TICKS       (SLOW_TICKS),
    .FAST_TICKS       (FAST_TICKS),
    .FAST_AFTER_TICKS (FAST_AFTER_TICKS)
  ) u_pace (
    .clk   (clk),
    .rst_n (rst_q),
    .up_q  (up_q),
    .dn_q  (dn_q),
    .inh   (inh),
    .mv    (mv)
  );

  tapstep_pos #(.POS_W(POS_W)) u_pos (
    .clk    (clk),
    .rst_n  (rst_q),
    .mv     (mv),
    .ld_stb (ld_stb),
    .ld_val (ld_val),
    .pos    (tap)
  );
endmodule

// File: rtl/tapstep_chk.sv
module tapstep_chk #(
  parameter int POS_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             up_q,
  input logic             dn_q,
  input logic             inh,
  input logic             ld_stb,
  input logic [POS_W-1:0] ld_val,
  input logic [POS_W-1:0] tap
);
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ld_stb |=> tap == $past(ld_val)); // R9
  AST_INHIBIT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (inh && !ld_stb) |=> $stable(tap)); // R10
  AST_BOTH_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (!up_q && !dn_q && !ld_stb) |=> $stable(tap)); // R8
  AST_IDLE_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && dn_q && !ld_stb) |=> $stable(tap)); // R7
  AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_stb |=> (tap == $past(tap) || tap == $past(tap) + 1'b1 || tap == $past(tap) - 1'b1)); // R3
  AST_UP_ONLY_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    (!up_q && dn_q && !ld_stb) |=> tap >= $past(tap)); // R3
  AST_DN_ONLY_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && !dn_q && !ld_stb) |=> tap <= $past(tap)); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (tap == '1 && !ld_stb) |=> tap != '0); // R6
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (tap == '0 && !ld_stb) |=> tap != '1); // R6
endmodule

bind tap_stepper tapstep_chk #(.POS_W(POS_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_q),
  .up_q   (up_q),
  .dn_q   (dn_q),
  .inh    (inh),
  .ld_stb (ld_stb),
  .ld_val (ld_val),
  .tap    (tap)
);

// File: tb/sim_tap_stepper.sv
`timescale 1ns/1ps
module sim_tap_stepper;
  localparam int CLK_PERIOD = 10;
  localparam int W   = 5;
  localparam int DEB = 4;
  localparam int SLW = 6;
  localparam int FST = 2;
  localparam int FA  = 20;
  localparam int TOP = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         up_n = 1'b1, dn_n = 1'b1, inh = 1'b0, ld_stb = 1'b0;
  logic [W-1:0] ld_val = '0;
  logic [W-1:0] tap;

  int    total = 0, bad = 0;
  bit    cmp_en = 1'b0;
  bit    done = 1'b0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  tap_stepper #(.POS_W(W), .DEB_TICKS(DEB), .SLOW_TICKS(SLW),
                .FAST_TICKS(FST), .FAST_AFTER_TICKS(FA)) u0 (
    .clk(clk), .rst_n(rst_n), .up_n(up_n), .dn_n(dn_n), .inh(inh),
    .ld_stb(ld_stb), .ld_val(ld_val), .tap(tap));

  // Behavioural reference: reset release delay, input delay line, hold timers.
  int m_tap, m_hold, m_since, m_rst_age;
  bit m_up_line[2], m_dn_line[2];
  bit m_last_up;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tap = 0; m_hold = 0; m_since = 0; m_rst_age = 0; m_last_up = 0;
      m_up_line = '{1, 1}; m_dn_line = '{1, 1};
    end else if (m_rst_age < 2) begin
      m_rst_age++;
    end else begin
      bit want_up, want_dn, moving, stepping;
      int held_now, gap_now, every;
      want_up  = !m_up_line[1];
      want_dn  = !m_dn_line[1];
      moving   = (want_up != want_dn) && !inh;
      stepping = 0;
      held_now = 0;
      gap_now  = 0;
      if (moving) begin
        if (m_hold > 0 && m_last_up == want_up) begin
          held_now = m_hold + 1;
          gap_now  = m_since;
        end else begin
          held_now = 1;
          gap_now  = 0;
        end
        if (held_now == DEB) stepping = 1;
        else if (held_now > DEB) begin
          gap_now++;
          every = (held_now > FA) ? FST : SLW;
          if (gap_now >= every) begin stepping = 1; gap_now = 0; end
        end
        if (held_now > FA + 1) held_now = FA + 1;
        m_last_up = want_up;
      end
      m_hold  = held_now;
      m_since = gap_now;
      if (ld_stb) m_tap = ld_val;
      else if (stepping && want_up && m_tap < TOP) m_tap++;
      else if (stepping && want_dn && m_tap > 0)   m_tap--;
      m_up_line[1] = m_up_line[0]; m_up_line[0] = up_n;
      m_dn_line[1] = m_dn_line[0]; m_dn_line[0] = dn_n;
    end
  end

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_en && !done) check(cur_req, int'(tap), m_tap);

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hold_btn(bit up, int n);
    @(negedge clk);
    if (up) up_n = 1'b0; else dn_n = 1'b0;
    idle(n);
    up_n = 1'b1; dn_n = 1'b1;
  endtask

  task automatic load(int v);
    @(negedge clk); ld_stb = 1'b1; ld_val = W'(v);
    @(negedge clk); ld_stb = 1'b0;
    idle(2);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);
    cmp_en = 1'b1;
    check("R1", int'(tap), 0);

    cur_req = "R2"; hold_btn(1, DEB - 1); idle(6);
    check("R2", int'(tap), 0);

    cur_req = "R3"; hold_btn(1, DEB); idle(6);
    check("R3", int'(tap), 1);
    hold_btn(0, DEB); idle(6);
    check("R3", int'(tap), 0);

    cur_req = "R4"; hold_btn(1, 12); idle(6);
    check("R4", int'(tap), 2);      // steps at held counts 4 and 10

    cur_req = "R5"; hold_btn(1, 30); idle(6);
    check("R5", int'(tap), 10);     // 4,10,16 slow then 21,23,25,27,29 fast

    cur_req = "R7";
    hold_btn(1, 8); idle(2); hold_btn(1, 8); idle(6);
    check("R7", int'(tap), 12);     // each press restarts debounce

    cur_req = "R9"; load(29);
    check("R9", int'(tap), 29);
    cur_req = "R6"; hold_btn(1, 30); idle(6);
    check("R6", int'(tap), TOP);
    load(2); hold_btn(0, 30); idle(6);
    check("R6", int'(tap), 0);

    cur_req = "R8"; load(15);
    @(negedge clk); up_n = 1'b0; dn_n = 1'b0;
    idle(30); up_n = 1'b1; dn_n = 1'b1; idle(6);
    check("R8", int'(tap), 15);
    // up held, down tapped in the middle: timers cleared, restart
    @(negedge clk); up_n = 1'b0; idle(3);
    dn_n = 1'b0; idle(2); dn_n = 1'b1; idle(6);
    up_n = 1'b1; idle(6);

    cur_req = "R10"; load(15);
    @(negedge clk); inh = 1'b1; up_n = 1'b0;
    idle(30); up_n = 1'b1; inh = 1'b0; idle(6);
    check("R10", int'(tap), 15);
    @(negedge clk); inh = 1'b1; up_n = 1'b0;
    idle(12); inh = 1'b0; idle(8); up_n = 1'b1; idle(6);
    check("R10", int'(tap), 17);    // ten active held cycles after inh drops

    cur_req = "R9"; load(5);
    @(negedge clk); up_n = 1'b0;
    idle(5); ld_stb = 1'b1; ld_val = W'(20);
    @(negedge clk); ld_stb = 1'b0;
    idle(2); up_n = 1'b1; idle(6);
    check("R9", int'(tap), 20);     // load lands on the first step cycle

    cur_req = "R3";
    @(negedge clk); up_n = 1'b0; idle(3);
    up_n = 1'b1; dn_n = 1'b0; idle(3); dn_n = 1'b1; idle(6);
    check("R3", int'(tap), 20);     // direction swap restarts debounce

    finish_run();
  end
endmodule